// File: doc/BRIEF.md
# Timer-Referenced Clock Speed Meter

This block finds out how fast its own system clock runs by counting system clock cycles across a known interval set by an external programmable interval timer. On a start strobe it drives a fixed setup sequence onto the timer's byte-wide register write port. It first clears its two control bits, the timer gate enable and the speaker enable. It then sends the one-shot command, loads a 16-bit divisor that makes the timer count down for 10 ms, and raises the gate. While raising the gate it samples a free-running cycle counter.

It then watches a synchronized copy of the timer's channel-2 output. When that output goes high, it samples the counter a second time and passes the difference to a sequential restoring divider. The quotient is the clock frequency in MHz when the scale divisor is 10,000. The result is held with a done flag until the next start. If the timer output never arrives, a timeout counted in reference clock ticks aborts the run and sets an error flag instead.

A status byte exposes the two control bits and synchronized copies of timer outputs 1 and 2. This lets the surrounding logic drive the timer gate and the speaker enable from the same register.

Top module: `csm_clock_meter`

## Requirements
- R1: After reset, gate_en, spk_en, done, err, mhz and tmr_we are all 0, and status reads 0x00 while both timer outputs are low.
- R2: The cycle after a start strobe is taken, gate_en (status bit 0) and spk_en (status bit 1) are cleared. They are already 0 in the cycle of the first timer write.
- R3: The first timer write is the command byte 0xB0 to address 3, meaning channel 2, low-then-high byte access, one-shot mode, binary count. It is issued in the second cycle after the start strobe is taken.
- R4: The next two cycles write the divisor REF_HZ/INTERVAL_DIV (11931 = 0x2E9B by default) to address 2, low byte 0x9B first and then high byte 0x2E. One idle cycle follows, after which gate_en rises to 1.
- R5: The elapsed count is the free-running counter value at the cycle in which synchronized OUT2 is first seen high, minus its value at the cycle in which the gate is set, taken modulo 2^CNT_W. mhz equals floor(elapsed / SCALE).
- R6: done rises CNT_W+1 cycles after the cycle in which synchronized OUT2 is first seen high, and mhz is valid from then on. The next accepted start clears done and err.
- R7: status bit 5 and bit 4 follow tmr_out2 and tmr_out1 through a SYNC_STAGES-flop synchronizer. Status bits 2, 3, 6 and 7 read 0.
- R8: If 2^TO_W ref_tick pulses arrive while waiting and OUT2 has not been seen, the run aborts. err goes to 1, gate_en goes to 0 and done stays 0.
- R9: A start strobe received while a measurement is running has no effect. No extra timer writes occur and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock being measured |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a measurement |
| ref_tick | input | 1 | One pulse per reference timer clock, for the timeout |
| tmr_out1 | input | 1 | Timer channel 1 output (asynchronous) |
| tmr_out2 | input | 1 | Timer channel 2 output (asynchronous) |
| tmr_we | output | 1 | Timer register write strobe |
| tmr_addr | output | 2 | Timer register address (0..2 channel data, 3 command) |
| tmr_wdata | output | 8 | Timer register write byte |
| gate_en | output | 1 | Timer channel 2 gate enable (control bit 0) |
| spk_en | output | 1 | Speaker enable (control bit 1) |
| status | output | 8 | Control/status byte: bit0 gate, bit1 speaker, bit4 OUT1, bit5 OUT2 |
| mhz | output | RES_W | Measured frequency, elapsed cycles / SCALE |
| done | output | 1 | Result valid |
| err | output | 1 | Measurement aborted by timeout |

## Verification
Counted from the edge that takes start, the command write appears after 1 edge, the two divisor bytes after 2 and 3 edges, and the gate after 5 edges. The bench samples each of these on the falling edge that follows its due edge. Once the bench raises OUT2, status bit 5 is due 2 edges later and the counter sample 3 edges later, so the expected quotient is (N+3)/SCALE when OUT2 is raised N edges after the gate. done is checked as still low 67 edges after OUT2 and high one edge after that. The timeout is checked at exactly the 2^TO_W-th ref_tick, together with err staying low one edge earlier.

// File: rtl/csm_pkg.sv
package csm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLR,
      ST_CMD,
      ST_LSB,
      ST_MSB,
      ST_GO,
      ST_WAIT,
      ST_DIV
   } csm_state_e;

   // timer port addresses: channel 2 data register and command register
   localparam logic [1:0] TADDR_CH2 = 2'd2;
   localparam logic [1:0] TADDR_CMD = 2'd3;
   // channel 2, low-then-high access, one-shot, binary
   localparam logic [7:0] TCMD_ONESHOT_CH2 = 8'hB0;
endpackage

// File: rtl/csm_cycle_counter.sv
module csm_cycle_counter #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + 1'b1;
   end

   // R5: counter advances by one each cycle, wrapping modulo 2^W
   a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> count == $past(count) + 1'b1);
endmodule

// File: rtl/csm_sync.sv
module csm_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/csm_divider.sv
module csm_divider #(
   parameter int unsigned W = 64
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic         vld
);
   localparam int unsigned IW = $clog2(W + 1);

   logic          busy;
   logic [IW-1:0] iter;
   logic [W:0]    trial;

   assign trial = {rem, quo[W-1]} - {1'b0, divisor};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         iter <= '0;
         quo  <= '0;
         rem  <= '0;
         vld  <= 1'b0;
      end else begin
         vld <= 1'b0;
         if (start && !busy) begin
            busy <= 1'b1;
            iter <= '0;
            quo  <= dividend;
            rem  <= '0;
         end else if (busy) begin
            if (!trial[W]) begin
               rem <= trial[W-1:0];
               quo <= {quo[W-2:0], 1'b1};
            end else begin
               rem <= {rem[W-2:0], quo[W-1]};
               quo <= {quo[W-2:0], 1'b0};
            end
            iter <= iter + 1'b1;
            if (iter == IW'(W - 1)) begin
               busy <= 1'b0;
               vld  <= 1'b1;
            end
         end
      end
   end

   // R5: a finished division leaves a remainder below the divisor
   a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
      vld |-> rem < divisor);
endmodule

// File: rtl/csm_clock_meter.sv
module csm_clock_meter
   import csm_pkg::*;
#(
   parameter int unsigned CNT_W        = 64,
   parameter int unsigned RES_W        = 32,
   parameter int unsigned REF_HZ       = 1193182,
   parameter int unsigned INTERVAL_DIV = 100,
   parameter int unsigned SCALE        = 10000,
   parameter int unsigned TO_W         = 24,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             ref_tick,
   input  logic             tmr_out1,
   input  logic             tmr_out2,
   output logic             tmr_we,
   output logic [1:0]       tmr_addr,
   output logic [7:0]       tmr_wdata,
   output logic             gate_en,
   output logic             spk_en,
   output logic [7:0]       status,
   output logic [RES_W-1:0] mhz,
   output logic             done,
   output logic             err
);
   localparam int unsigned     DIVISOR = REF_HZ / INTERVAL_DIV;
   localparam logic [15:0]     DIV16   = 16'(DIVISOR);
   localparam logic [CNT_W-1:0] SCALE_V = CNT_W'(SCALE);

   if (CNT_W < RES_W || CNT_W < 8) begin : g_bad_cnt_w
      $error("CNT_W must be at least RES_W and at least 8");
   end
   if (DIVISOR == 0 || DIVISOR > 65535) begin : g_bad_divisor
      $error("REF_HZ/INTERVAL_DIV must fit the 16-bit timer count");
   end
   if (SCALE == 0) begin : g_bad_scale
      $error("SCALE must be non-zero");
   end
   if (SYNC_STAGES < 2 || TO_W < 1) begin : g_bad_misc
      $error("SYNC_STAGES must be at least 2 and TO_W at least 1");
   end

   csm_state_e       state;
   logic [CNT_W-1:0] cnt, t0, elapsed, quo, rem;
   logic [1:0]       outs_s;
   logic [TO_W-1:0]  to_cnt;
   logic             div_start, div_vld;

   csm_cycle_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .count(cnt));

   csm_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({tmr_out2, tmr_out1}), .q(outs_s));

   assign elapsed   = cnt - t0;
   assign div_start = (state == ST_WAIT) && outs_s[1];

   csm_divider #(.W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(elapsed),
      .divisor(SCALE_V), .quo(quo), .rem(rem), .vld(div_vld));

   // timer write port decoded from the sequence state
   always_comb begin
      tmr_we    = 1'b0;
      tmr_addr  = TADDR_CH2;
      tmr_wdata = '0;
      unique case (state)
         ST_CMD: begin tmr_we = 1'b1; tmr_addr = TADDR_CMD; tmr_wdata = TCMD_ONESHOT_CH2; end
         ST_LSB: begin tmr_we = 1'b1; tmr_wdata = DIV16[7:0];  end
         ST_MSB: begin tmr_we = 1'b1; tmr_wdata = DIV16[15:8]; end
         default: ;
      endcase
   end

   assign status = {2'b00, outs_s[1], outs_s[0], 2'b00, spk_en, gate_en};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         gate_en <= 1'b0;
         spk_en  <= 1'b0;
         t0      <= '0;
         to_cnt  <= '0;
         mhz     <= '0;
         done    <= 1'b0;
         err     <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: if (start) begin
               state <= ST_CLR;
               done  <= 1'b0;
               err   <= 1'b0;
            end
            ST_CLR: begin
               gate_en <= 1'b0;
               spk_en  <= 1'b0;
               state   <= ST_CMD;
            end
            ST_CMD: state <= ST_LSB;
            ST_LSB: state <= ST_MSB;
            ST_MSB: state <= ST_GO;
            ST_GO: begin
               gate_en <= 1'b1;
               t0      <= cnt;
               to_cnt  <= '0;
               state   <= ST_WAIT;
            end
            ST_WAIT: begin
               if (outs_s[1]) begin
                  state <= ST_DIV;
               end else if (ref_tick) begin
                  if (to_cnt == '1) begin
                     err     <= 1'b1;
                     gate_en <= 1'b0;
                     state   <= ST_IDLE;
                  end else begin
                     to_cnt <= to_cnt + 1'b1;
                  end
               end
            end
            ST_DIV: if (div_vld) begin
               mhz   <= quo[RES_W-1:0];
               done  <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R2: both control bits are clear whenever the command byte goes out
   a_r2_ctl_clear_at_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_we && tmr_addr == TADDR_CMD) |-> (!gate_en && !spk_en));

   // R4: the gate only rises two cycles after the high divisor byte
   a_r4_gate_after_msb: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en) |-> ($past(tmr_we, 2) && $past(tmr_addr, 2) == TADDR_CH2));

   // R8: a run ends either with a result or with an error, never both
   a_r8_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R9: the result stays put while no new run has been accepted
   a_r9_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(mhz));
endmodule

// File: tb/csm_clock_meter_tb.sv
module csm_clock_meter_tb;
   localparam int unsigned SCALE = 100;
   localparam int unsigned TO_W  = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, ref_tick = 1'b0, out1 = 1'b0, out2 = 1'b0;
   logic        tmr_we, gate_en, spk_en, done, err;
   logic [1:0]  tmr_addr;
   logic [7:0]  tmr_wdata, status;
   logic [31:0] mhz;

   int n_chk = 0, n_fail = 0, n_wr = 0;

   always #5 clk = ~clk;

   csm_clock_meter #(.SCALE(SCALE), .TO_W(TO_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_tick(ref_tick),
      .tmr_out1(out1), .tmr_out2(out2), .tmr_we(tmr_we), .tmr_addr(tmr_addr),
      .tmr_wdata(tmr_wdata), .gate_en(gate_en), .spk_en(spk_en),
      .status(status), .mhz(mhz), .done(done), .err(err));

   // count timer writes seen on the port
   always @(negedge clk) if (rst_n && tmr_we) n_wr++;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // one measurement; out2 raised n edges after the gate edge
   task automatic measure(input int n, input bit timeout, input bit poke);
      int wr0;
      start = 1'b1;
      step(1);
      start = 1'b0;
      wr0 = n_wr;
      chk(!done && !err, "R6 cleared by start", {done, err}, 0);
      step(1);
      chk(status[1:0] == 2'b00, "R2 ctl bits cleared", status[1:0], 0);
      chk(tmr_we && tmr_addr == 2'd3 && tmr_wdata == 8'hB0, "R3 command write",
          {tmr_we, tmr_addr, tmr_wdata}, {1'b1, 2'd3, 8'hB0});
      out2 = 1'b0;  // one-shot output drops on the command write
      step(1);
      chk(tmr_we && tmr_addr == 2'd2 && tmr_wdata == 8'h9B, "R4 divisor low",
          {tmr_we, tmr_addr, tmr_wdata}, {1'b1, 2'd2, 8'h9B});
      step(1);
      chk(tmr_we && tmr_addr == 2'd2 && tmr_wdata == 8'h2E, "R4 divisor high",
          {tmr_we, tmr_addr, tmr_wdata}, {1'b1, 2'd2, 8'h2E});
      step(1);
      chk(!tmr_we && !gate_en, "R4 idle cycle before gate", {tmr_we, gate_en}, 0);
      step(1);
      chk(gate_en && status[0], "R4 gate raised", {gate_en, status[0]}, 2'b11);
      if (timeout) begin
         ref_tick = 1'b1;
         step((1 << TO_W) - 1);
         chk(!err, "R8 no abort before limit", err, 0);
         step(1);
         chk(err && !gate_en && !done, "R8 timeout abort", {err, gate_en, done}, 3'b100);
         ref_tick = 1'b0;
      end else begin
         if (poke) begin
            start = 1'b1;
            step(1);
            start = 1'b0;
            step(n - 1);
         end else begin
            step(n);
         end
         out2 = 1'b1;
         step(1);
         chk(!status[5], "R7 OUT2 still in synchronizer", status[5], 0);
         step(1);
         chk(status[5], "R7 OUT2 visible", status[5], 1);
         step(65);
         chk(!done, "R6 done not early", done, 0);
         step(1);
         chk(done, "R6 done on time", done, 1);
         chk(mhz == (n + 3) / SCALE, "R5 quotient", mhz, (n + 3) / SCALE);
         chk(n_wr - wr0 == 3, "R9 three timer writes per run", n_wr - wr0, 3);
         step(3);
         chk(done && mhz == (n + 3) / SCALE, "R9 result held", mhz, (n + 3) / SCALE);
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(!gate_en && !spk_en && !done && !err && mhz == 0 && !tmr_we, "R1 reset state",
          {gate_en, spk_en, done, err, tmr_we}, 0);
      chk(status == 8'h00, "R1 status at reset", status, 0);
      out1 = 1'b1;
      step(1);
      chk(!status[4], "R7 OUT1 still in synchronizer", status[4], 0);
      step(1);
      chk(status[4] && status[7:6] == 0 && status[3:2] == 0, "R7 OUT1 visible, spare bits 0",
          status, 8'h10);
      out1 = 1'b0;
      measure(297, 1'b0, 1'b0);   // elapsed 300 -> 3
      measure(296, 1'b0, 1'b0);   // elapsed 299 -> 2
      measure(40, 1'b0, 1'b0);    // elapsed 43  -> 0
      measure(1000, 1'b0, 1'b1);  // elapsed 1003 -> 10, start poked while busy
      measure(0, 1'b1, 1'b0);     // no OUT2: timeout
      measure(497, 1'b0, 1'b0);   // err cleared, elapsed 500 -> 5
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule